// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Port (Master or Slave)

This block is a byte-wide synchronous serial port for a small microcontroller. Software reaches it through three registers on a plain read/write bus: a control register, a status register and a data register. With the master bit set, a write to the data register clocks eight bits out on the serial data-out pin. At the same time eight bits are sampled from the serial data-in pin. The port generates the serial clock itself, at one of four fixed fractions of the system clock. With the master bit clear, the port waits for an external master. It shifts only while the select input is low.

Both clock idle levels and both sampling phases are supported, and either bit order can be chosen. When a byte finishes, a sticky completion flag is set. A write to the data register during a byte is discarded and raises a sticky collision flag. The interrupt output needs the completion flag, the port's own interrupt enable and an external serial-interrupt enable all at 1. Every serial pin has its own output-enable. When the port is disabled, all of these enables are low.

Top module: `spi_port`

## Requirements
- R1: After reset the control register reads 00h, the status register reads 00h, every pin output-enable is 0 and irq is 0.
- R2: Register addresses are 0 control, 1 status, 2 data, and address 3 reads 00h. Control bits 7..0 are: interrupt enable, port enable, lsb-first, master, clock polarity, clock phase, rate[1], rate[0]. Status bit 7 is the completion flag, bit 6 is the collision flag, and bits 5..0 read 0. The data address reads the shift register.
- R3: With port enable 0, sck_oe, mosi_oe and miso_oe are 0, and a data write starts no transfer.
- R4: In master mode with the port enabled, a data write while idle starts a transfer of exactly 16 SCK edges. Between transfers sck_o rests at the clock polarity bit.
- R5: In master mode, consecutive SCK edges are 2, 8, 32 or 64 system cycles apart for rate 0, 1, 2 or 3, giving SCK periods of 4, 16, 64 and 128 cycles.
- R6: With clock phase 0, the first bit is on the data output before the first (leading) edge, input is sampled on leading edges and the output changes on trailing edges. With clock phase 1, the output changes on leading edges and input is sampled on trailing edges.
- R7: With lsb-first 0 the bits travel bit 7 first. With lsb-first 1 they travel bit 0 first. This holds for both sent and received bytes.
- R8: The completion flag sets on the final edge of a byte, and the data register then holds the received byte. The flag is cleared only by writing the status register with bit 7 = 1.
- R9: A data write during a transfer sets the collision flag. The written value is discarded and the bits sent and received are unchanged. The collision flag is cleared only by writing the status register with bit 6 = 1.
- R10: irq is 1 exactly when the completion flag, the interrupt-enable control bit and serial_irq_en are all 1.
- R11: In slave mode the port shifts on sck_i edges only while ss_n_i is low, and the rate bits have no effect. miso_oe is 1 only while selected, and sck_oe and mosi_oe stay 0.
- R12: In slave mode, raising ss_n_i part-way through a byte aborts it without setting the completion flag. The next byte starts again from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational on bus_addr) |
| serial_irq_en | input | 1 | External serial-interrupt enable |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock generated in master mode |
| sck_oe | output | 1 | Drive enable for sck_o |
| mosi_i | input | 1 | Serial data in (slave mode) |
| mosi_o | output | 1 | Serial data out (master mode) |
| mosi_oe | output | 1 | Drive enable for mosi_o |
| miso_i | input | 1 | Serial data in (master mode) |
| miso_o | output | 1 | Serial data out (slave mode) |
| miso_oe | output | 1 | Drive enable for miso_o |
| ss_n_i | input | 1 | Active-low slave select |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach from the ports are a data write that lands in the middle of a running byte and a select that rises between two bits. The bench acts as the far end of the link itself. While a master transfer runs, it counts the SCK edges it sees and issues the colliding write right after the fifth edge. As a slave-side master, it stops after three bits and raises the select. It then runs a full byte to show that the bit count started again from zero.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam int unsigned REG_W = 8;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  localparam int unsigned DONE_BIT = 7;
  localparam int unsigned COLL_BIT = 6;

  typedef struct packed {
    logic       ie;
    logic       en;
    logic       lsb_first;
    logic       mstr;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } spi_ctrl_t;

  // System cycles between two SCK edges for each rate code.
  function automatic int unsigned half_period(input logic [1:0] rate);
    case (rate)
      2'd0:    return 2;
      2'd1:    return 8;
      2'd2:    return 32;
      default: return 64;
    endcase
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [WIDTH-1:0] r;
    logic [WIDTH-1:0] nxt;
    if (s == 0) begin : g_first
      assign nxt = d;
    end else begin : g_next
      assign nxt = g_stg[s-1].r;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= RST_VAL;
      else        r <= nxt;
    end
  end

  assign q = g_stg[STAGES-1].r;

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import spi_port_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick,
  output logic       sck_lvl
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;

  assign half = DIV_W'(half_period(rate));
  assign tick = run && (cnt == half - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      sck_lvl <= 1'b0;
    end else if (!run) begin
      cnt     <= '0;
      sck_lvl <= 1'b0;
    end else if (tick) begin
      cnt     <= '0;
      sck_lvl <= ~sck_lvl;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  // R5
  sck_rise_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_lvl) |-> $past(run));

  // R5
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            sck_edge,
  input  logic            rx_bit,
  input  logic            cpha,
  input  logic            lsb_first,
  input  logic            load,
  input  logic [BITS-1:0] load_val,
  output logic [BITS-1:0] sreg,
  output logic            tx_bit,
  output logic            busy,
  output logic            done
);

  localparam int EDGES = 2 * BITS;
  localparam int CNT_W = $clog2(EDGES);

  function automatic logic lane_out(input logic [BITS-1:0] v, input logic lsb);
    return lsb ? v[0] : v[BITS-1];
  endfunction

  function automatic logic [BITS-1:0] lane_in(input logic [BITS-1:0] v,
                                              input logic b, input logic lsb);
    return lsb ? {b, v[BITS-1:1]} : {v[BITS-2:0], b};
  endfunction

  logic [CNT_W-1:0] edge_cnt;
  logic             lead;
  logic             step;
  logic             capture;
  logic             abort;

  assign lead    = ~edge_cnt[0];
  assign step    = sck_edge && active;
  assign capture = step && (lead ^ cpha);
  assign busy    = edge_cnt != '0;
  assign done    = step && (edge_cnt == CNT_W'(EDGES - 1));
  assign abort   = !active && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg     <= '0;
      tx_bit   <= 1'b0;
      edge_cnt <= '0;
    end else if (load) begin
      sreg   <= load_val;
      tx_bit <= lane_out(load_val, lsb_first);
    end else if (abort) begin
      edge_cnt <= '0;
      tx_bit   <= lane_out(sreg, lsb_first);
    end else if (step) begin
      edge_cnt <= done ? '0 : edge_cnt + CNT_W'(1);
      if (capture) sreg   <= lane_in(sreg, rx_bit, lsb_first);
      else         tx_bit <= lane_out(sreg, lsb_first);
    end
  end

  // R12
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);

  // R9
  sreg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load || capture) |=> $stable(sreg));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DIV_W = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             serial_irq_en,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             sck_oe,
  input  logic             mosi_i,
  output logic             mosi_o,
  output logic             mosi_oe,
  input  logic             miso_i,
  output logic             miso_o,
  output logic             miso_oe,
  input  logic             ss_n_i,
  output logic             irq
);

  spi_ctrl_t        ctrl_q;
  logic             spif_q;
  logic             wcol_q;
  logic             run_q;
  logic             sck_prev;

  logic             ctrl_wr;
  logic             stat_wr;
  logic             data_wr;
  logic             busy_any;
  logic             start;
  logic             load;
  logic             collide;

  logic             tick;
  logic             sck_lvl;
  logic             ss_s;
  logic             sck_s;
  logic             mosi_s;
  logic             slave_sel;
  logic             slave_edge;

  logic             sck_edge;
  logic             rx_bit;
  logic             active;
  logic [REG_W-1:0] sreg;
  logic             tx_bit;
  logic             sh_busy;
  logic             xfer_done;

  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);
  assign data_wr = bus_wr && (bus_addr == A_DATA);

  assign busy_any = run_q || sh_busy;
  assign load     = data_wr && !busy_any;
  assign collide  = data_wr && busy_any;
  assign start    = load && ctrl_q.en && ctrl_q.mstr;

  spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ss_n_i, sck_i, mosi_i}),
    .q    ({ss_s, sck_s, mosi_s})
  );

  assign slave_sel  = ctrl_q.en && !ctrl_q.mstr && !ss_s;
  assign slave_edge = slave_sel && (sck_s != sck_prev);

  spi_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_q),
    .rate   (ctrl_q.rate),
    .tick   (tick),
    .sck_lvl(sck_lvl)
  );

  assign sck_edge = ctrl_q.mstr ? tick   : slave_edge;
  assign rx_bit   = ctrl_q.mstr ? miso_i : mosi_s;
  assign active   = ctrl_q.mstr ? run_q  : slave_sel;

  spi_shifter #(.BITS(REG_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .sck_edge (sck_edge),
    .rx_bit   (rx_bit),
    .cpha     (ctrl_q.cpha),
    .lsb_first(ctrl_q.lsb_first),
    .load     (load),
    .load_val (bus_wdata),
    .sreg     (sreg),
    .tx_bit   (tx_bit),
    .busy     (sh_busy),
    .done     (xfer_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      spif_q   <= 1'b0;
      wcol_q   <= 1'b0;
      run_q    <= 1'b0;
      sck_prev <= 1'b0;
    end else begin
      sck_prev <= sck_s;
      if (ctrl_wr) ctrl_q <= spi_ctrl_t'(bus_wdata);

      if (!ctrl_q.en || !ctrl_q.mstr) run_q <= 1'b0;
      else if (start)                 run_q <= 1'b1;
      else if (xfer_done)             run_q <= 1'b0;

      if (xfer_done)                          spif_q <= 1'b1;
      else if (stat_wr && bus_wdata[DONE_BIT]) spif_q <= 1'b0;

      if (collide)                            wcol_q <= 1'b1;
      else if (stat_wr && bus_wdata[COLL_BIT]) wcol_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_STAT:  bus_rdata = {spif_q, wcol_q, 6'b0};
      A_DATA:  bus_rdata = sreg;
      default: bus_rdata = '0;
    endcase
  end

  assign sck_o   = ctrl_q.cpol ^ sck_lvl;
  assign sck_oe  = ctrl_q.en && ctrl_q.mstr;
  assign mosi_o  = tx_bit;
  assign mosi_oe = ctrl_q.en && ctrl_q.mstr;
  assign miso_o  = tx_bit;
  assign miso_oe = slave_sel;
  assign irq     = spif_q && ctrl_q.ie && serial_irq_en;

  // R8
  spif_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spif_q) |-> $past(xfer_done));

  // R9
  wcol_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wcol_q) |-> $past(data_wr && busy_any));

  // R3
  off_no_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.en |=> !run_q);

  // R11
  deselect_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.mstr && ss_s) |-> !xfer_done);

endmodule

// File: tb/tb_spi_port.sv
module tb_spi_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       serial_irq_en = 1'b0;
  logic       sck_i = 1'b0;
  logic       sck_o, sck_oe;
  logic       mosi_i = 1'b0;
  logic       mosi_o, mosi_oe;
  logic       miso_i = 1'b0;
  logic       miso_o, miso_oe;
  logic       ss_n_i = 1'b1;
  logic       irq;

  int checks = 0;
  int errors = 0;

  localparam int SLV_H = 6;

  always #10 clk = ~clk;

  spi_port dut (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .serial_irq_en(serial_irq_en),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .ss_n_i(ss_n_i), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] cfg(input bit ie, input bit en, input bit lsb, input bit mstr,
                                     input bit cpol, input bit cpha, input logic [1:0] rate);
    return {ie, en, lsb, mstr, cpol, cpha, rate};
  endfunction

  function automatic logic seq_bit(input logic [7:0] v, input bit lsb, input int k);
    return lsb ? v[k] : v[7-k];
  endfunction

  function automatic int half_of(input logic [1:0] rate);
    int per;
    per = (rate == 2'd3) ? 128 : (4 << (2 * rate));
    return per / 2;
  endfunction

  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] srx, input bit cpol,
                             input bit cpha, input bit lsb, input logic [1:0] rate,
                             input bit collide, input bit keep, input bit ie);
    logic [7:0] rec, rd;
    logic prev;
    int edges, gap, iters, cap_i, chg_i, half;
    bit gap_ok, col_done, lead;
    half = half_of(rate);
    bus_write(2'd0, cfg(ie, 1'b1, lsb, 1'b1, cpol, cpha, rate));
    check(sck_o == cpol, "R4 idle sck before", sck_o, cpol);
    miso_i = seq_bit(srx, lsb, 0);
    bus_write(2'd2, tx);
    prev = sck_o; edges = 0; gap = 0; iters = 0; cap_i = 0; chg_i = 0;
    gap_ok = 1'b1; col_done = 1'b0; rec = 8'h00;
    while (edges < 16 && iters < 5000) begin
      @(negedge clk);
      iters++; gap++;
      if (bus_wr) bus_wr = 1'b0;
      if (sck_o !== prev) begin
        if (edges > 0 && gap != half) gap_ok = 1'b0;
        gap = 0; edges++; prev = sck_o;
        lead = (edges % 2) == 1;
        if (lead ^ cpha) begin
          if (cap_i < 8) begin
            if (lsb) rec[cap_i] = mosi_o; else rec[7-cap_i] = mosi_o;
          end
          cap_i++;
        end else begin
          if (cpha == 1'b0) begin
            if (chg_i + 1 < 8) miso_i = seq_bit(srx, lsb, chg_i + 1);
          end else begin
            if (chg_i < 8) miso_i = seq_bit(srx, lsb, chg_i);
          end
          chg_i++;
        end
      end
      if (collide && edges == 5 && !col_done) begin
        bus_addr = 2'd2; bus_wdata = ~tx; bus_wr = 1'b1; col_done = 1'b1;
      end
    end
    check(edges == 16, "R4 sck edge count", edges, 16);
    check(gap_ok, "R5 sck half period", gap_ok, 1);
    @(negedge clk); @(negedge clk);
    check(sck_o == cpol, "R4 idle sck after", sck_o, cpol);
    check(rec == tx, "R6 R7 bits on mosi", rec, tx);
    bus_read(2'd2, rd);
    check(rd == srx, "R7 R8 received byte", rd, srx);
    bus_read(2'd1, rd);
    check(rd == {1'b1, collide, 6'b0}, "R8 R9 status after byte", rd, {1'b1, collide, 6'b0});
    if (!keep) bus_write(2'd1, 8'hC0);
  endtask

  task automatic slave_xfer(input logic [7:0] mtx, input logic [7:0] stx, input bit cpol,
                            input bit cpha, input bit lsb, input logic [1:0] rate,
                            input int stop_after);
    logic [7:0] rec, rd;
    int nb;
    nb = (stop_after > 0) ? stop_after : 8;
    bus_write(2'd0, cfg(1'b0, 1'b1, lsb, 1'b0, cpol, cpha, rate));
    sck_i = cpol; ss_n_i = 1'b1; mosi_i = 1'b0;
    repeat (4) @(negedge clk);
    check(miso_oe == 1'b0, "R11 miso idle while deselected", miso_oe, 0);
    bus_write(2'd2, stx);
    ss_n_i = 1'b0;
    repeat (SLV_H) @(negedge clk);
    check({sck_oe, mosi_oe, miso_oe} == 3'b001, "R11 slave pin enables",
          {sck_oe, mosi_oe, miso_oe}, 3'b001);
    rec = 8'h00;
    for (int i = 0; i < nb; i++) begin
      if (!cpha) begin
        mosi_i = seq_bit(mtx, lsb, i);
        repeat (SLV_H) @(negedge clk);
        if (lsb) rec[i] = miso_o; else rec[7-i] = miso_o;
        sck_i = ~cpol;
        repeat (SLV_H) @(negedge clk);
        sck_i = cpol;
      end else begin
        sck_i = ~cpol;
        mosi_i = seq_bit(mtx, lsb, i);
        repeat (SLV_H) @(negedge clk);
        if (lsb) rec[i] = miso_o; else rec[7-i] = miso_o;
        sck_i = cpol;
        repeat (SLV_H) @(negedge clk);
      end
    end
    repeat (SLV_H) @(negedge clk);
    if (stop_after > 0) begin
      ss_n_i = 1'b1;
      repeat (8) @(negedge clk);
      bus_read(2'd1, rd);
      check(rd[7] == 1'b0, "R12 no completion on abort", rd[7], 0);
    end else begin
      bus_read(2'd1, rd);
      check(rd[7] == 1'b1, "R11 slave completion flag", rd[7], 1);
      bus_read(2'd2, rd);
      check(rd == mtx, "R11 R7 slave received byte", rd, mtx);
      check(rec == stx, "R6 R11 slave bits on miso", rec, stx);
      ss_n_i = 1'b1;
      repeat (4) @(negedge clk);
      bus_write(2'd1, 8'hC0);
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] tx, srx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(2'd0, rd);
    check(rd == 8'h00, "R1 control reset", rd, 0);
    bus_read(2'd1, rd);
    check(rd == 8'h00, "R1 status reset", rd, 0);
    check({sck_oe, mosi_oe, miso_oe, irq} == 4'b0, "R1 pins and irq after reset",
          {sck_oe, mosi_oe, miso_oe, irq}, 0);

    // R2 register map read-back
    bus_write(2'd0, 8'h2D);
    bus_read(2'd0, rd);
    check(rd == 8'h2D, "R2 control read-back", rd, 8'h2D);
    bus_read(2'd3, rd);
    check(rd == 8'h00, "R2 unused address", rd, 0);

    // R3 disabled port
    bus_write(2'd0, cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0));
    check({sck_oe, mosi_oe, miso_oe} == 3'b0, "R3 pins undriven when off",
          {sck_oe, mosi_oe, miso_oe}, 0);
    bus_write(2'd2, 8'h5A);
    repeat (300) @(negedge clk);
    bus_read(2'd1, rd);
    check(rd == 8'h00, "R3 no transfer when off", rd, 0);
    bus_read(2'd2, rd);
    check(rd == 8'h5A, "R2 data read-back", rd, 8'h5A);

    // R4 R5 R6 R7 R8 sweep of master configurations
    for (int m = 0; m < 32; m++) begin
      tx  = 8'(m * 37 + 8'h4B);
      srx = 8'(m * 91 + 8'hA6);
      master_xfer(tx, srx, m[3], m[2], m[4], m[1:0], 1'b0, 1'b0, 1'b0);
    end

    // R9 collision mid-byte, both flags kept
    master_xfer(8'hC3, 8'h3C, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1);
    bus_write(2'd1, 8'h40);
    bus_read(2'd1, rd);
    check(rd == 8'h80, "R9 collision cleared alone", rd, 8'h80);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, rd);
    check(rd == 8'h80, "R8 zero write keeps flag", rd, 8'h80);

    // R10 interrupt gating
    serial_irq_en = 1'b0; #1;
    check(irq == 1'b0, "R10 irq blocked by serial enable", irq, 0);
    serial_irq_en = 1'b1; #1;
    check(irq == 1'b1, "R10 irq raised", irq, 1);
    bus_write(2'd0, cfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0));
    check(irq == 1'b0, "R10 irq blocked by local enable", irq, 0);
    bus_write(2'd0, cfg(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0));
    check(irq == 1'b1, "R10 irq re-enabled", irq, 1);
    bus_write(2'd1, 8'h80);
    check(irq == 1'b0, "R10 irq after clear", irq, 0);
    bus_read(2'd1, rd);
    check(rd == 8'h00, "R8 flag cleared by write", rd, 0);
    serial_irq_en = 1'b0;

    // R11 slave sweep, rate bits set to show they are ignored
    for (int s = 0; s < 8; s++) begin
      slave_xfer(8'(s * 29 + 8'h17), 8'(s * 53 + 8'hE1), s[1], s[0], s[2], 2'(s), 0);
    end

    // R12 abort after three bits then a clean byte
    slave_xfer(8'hFF, 8'h81, 1'b0, 1'b0, 1'b0, 2'd0, 3);
    slave_xfer(8'h6E, 8'h94, 1'b0, 1'b0, 1'b0, 2'd0, 0);
    bus_read(2'd1, rd);
    check(rd == 8'h00, "R12 no collision after abort", rd, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule